// File: doc/BRIEF.md
# Output Buffer Trim Calibration Sequencer

This block finds the offset trim code for the output buffer of one converter channel. A one-cycle start pulse launches the search. The block first takes the channel-enable control low. It then drives trim code zero and raises the code by one per step. Each code is held for a fixed settling window before the comparator's calibration flag is looked at. The flag comes from an analog comparator that sits outside this block. The search stops at the first code for which the flag reads set. If the top code is tried and the flag is still clear, the block stops there with an error indication and keeps the top code on its output.

The settling window is given in microseconds together with the clock frequency, and the block turns that into a cycle count. The calibration flag crosses into the clock domain through a two-flop synchronizer before the sequencer uses it. Once a search has finished, the channel stays disabled until the requester drops its enable request and raises it again. A channel that was enabled before calibration is therefore never switched back on without being asked.

State machine: `ST_IDLE` waits for start. `ST_CLEAR` drops the channel and zeroes the code. `ST_SETTLE` counts out the settling window. `ST_PROBE` evaluates the synchronized flag. `ST_FINISH` emits the done pulse. The transitions are:
- IDLE→CLEAR on start.
- CLEAR→SETTLE always.
- SETTLE→PROBE when the window expires.
- PROBE→SETTLE with code+1 when the flag is clear below the top code.
- PROBE→FINISH when the flag is set, or when the top code is reached.
- FINISH→IDLE always.

Top module: `trim_cal_seq`

## Requirements
- R1: During and after reset, with no start yet, trim_o is 0, busy_o is 0, done_o is 0 and err_o is 0, and chan_en_o equals en_req_i.
- R2: A start_i sampled high while idle makes busy_o 1, trim_o 0 and chan_en_o 0 from the next cycle on. chan_en_o stays 0 for as long as busy_o is 1.
- R3: Each trim code is held for SETTLE_CYC = (CLK_HZ/1e6)*SETTLE_US cycles, and the flag is evaluated in the following cycle. When code t ends the search, done_o rises exactly 1+(t+1)*(SETTLE_CYC+1) clock edges after the edge that sampled start_i.
- R4: The search ends at the first code whose evaluation sees the synchronized flag set. trim_o then holds that code and err_o is 0.
- R5: While busy_o is 1, trim_o only ever changes by +1. A clear flag advances the code by exactly one step.
- R6: If the flag is clear when code 31 (the top 5-bit code) is evaluated, the search ends with err_o set to 1 and trim_o held at 31.
- R7: done_o is high for exactly one cycle per search, and busy_o is 0 in that cycle.
- R8: After a search ends, chan_en_o stays 0 while en_req_i stays high. It follows en_req_i again only after en_req_i has been seen low for at least one idle cycle.
- R9: A start_i pulse while busy_o is 1 is ignored. The code sequence and the completion time are unchanged.
- R10: err_o keeps its value after a search until the next accepted start, which clears it from the cycle after start.
- R11: The calibration flag passes through two flip-flops before it is evaluated. A flag that rises after the edge one before the evaluation cycle is not seen until the next code, while one that rises one cycle earlier is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a calibration search (pulse, taken while idle) |
| cal_flag_i | input | 1 | Comparator calibration flag, asynchronous |
| en_req_i | input | 1 | Requested channel enable from the owner of the channel |
| trim_o | output | TRIM_W | Trim code applied to the output buffer |
| chan_en_o | output | 1 | Channel-enable control |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle pulse when a search ends |
| err_o | output | 1 | Last search reached the top code without the flag |

## Verification
A wrong state transition or a miscounted settling window changes the moment done_o rises. That moment is pinned to a single clock edge, so one extra or missing cycle per code shows up as a latency error at the end of the same search. A bad code step shows on trim_o within one settling window. A missing or extra synchronizer stage moves the point at which a late-rising flag is first seen by one code, and this appears in the final trim_o. A hold-off flag that is not cleared or not set shows on chan_en_o in the first idle cycle after done_o.

// File: rtl/trimcal_pkg.sv
package trimcal_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_SETTLE,
        ST_PROBE,
        ST_FINISH
    } cal_state_e;

    function automatic int cycles_from_us(input longint clk_hz, input int us);
        longint c;
        c = (clk_hz / 64'd1_000_000) * longint'(us);
        if (c < 1) c = 1;
        return int'(c);
    endfunction

endpackage

// File: rtl/trimcal_sync.sv
module trimcal_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] stage_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[0] <= 1'b0;
                else        stage_q[0] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= 1'b0;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/trimcal_timer.sv
module trimcal_timer #(
    parameter int CYC = 8000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic expired_o
);
    localparam int CNT_W = (CYC > 1) ? $clog2(CYC) : 1;
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load_i)         cnt_q <= RELOAD;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign expired_o = (cnt_q == '0);

    // R3: the window counter never exceeds its reload value
    a_r3_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= RELOAD);

    // R3: a reload always starts a fresh, unexpired window (CYC > 1)
    a_r3_reload_fresh: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && CYC > 1) |=> !expired_o);
endmodule

// File: rtl/trimcal_code.sv
module trimcal_code #(
    parameter int TRIM_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              inc_i,
    output logic [TRIM_W-1:0] code_o,
    output logic              at_max_o
);
    localparam logic [TRIM_W-1:0] TOP = {TRIM_W{1'b1}};

    logic [TRIM_W-1:0] code_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      code_q <= '0;
        else if (clr_i)  code_q <= '0;
        else if (inc_i)  code_q <= code_q + 1'b1;
    end

    assign code_o   = code_q;
    assign at_max_o = (code_q == TOP);

    // R6: the sequencer never asks for a step past the top code
    a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        inc_i |-> !at_max_o);
endmodule

// File: rtl/trim_cal_seq.sv
module trim_cal_seq #(
    parameter longint CLK_HZ      = 125_000_000,
    parameter int     SETTLE_US   = 64,
    parameter int     TRIM_W      = 5,
    parameter int     SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              cal_flag_i,
    input  logic              en_req_i,
    output logic [TRIM_W-1:0] trim_o,
    output logic              chan_en_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o
);
    import trimcal_pkg::*;

    localparam int SETTLE_CYC = cycles_from_us(CLK_HZ, SETTLE_US);
    localparam logic [TRIM_W-1:0] TRIM_TOP = {TRIM_W{1'b1}};

    cal_state_e state_q, state_d;
    logic flag_s, win_done, code_top;
    logic code_clr, code_inc, win_load, accept;
    logic err_q, hold_q;

    trimcal_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(cal_flag_i), .q_o(flag_s));

    trimcal_timer #(.CYC(SETTLE_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .load_i(win_load), .expired_o(win_done));

    trimcal_code #(.TRIM_W(TRIM_W)) u_code (
        .clk(clk), .rst_n(rst_n), .clr_i(code_clr), .inc_i(code_inc),
        .code_o(trim_o), .at_max_o(code_top));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_CLEAR;
            ST_CLEAR:  state_d = ST_SETTLE;
            ST_SETTLE: if (win_done) state_d = ST_PROBE;
            ST_PROBE:  state_d = (flag_s || code_top) ? ST_FINISH : ST_SETTLE;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // datapath controls
    assign accept   = (state_q == ST_IDLE) && start_i;
    assign code_clr = accept;
    assign code_inc = (state_q == ST_PROBE) && !flag_s && !code_top;
    assign win_load = (state_q == ST_CLEAR) || code_inc;

    // error and enable hold-off flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q  <= 1'b0;
            hold_q <= 1'b0;
        end else begin
            if (accept)
                err_q <= 1'b0;
            else if (state_q == ST_PROBE && !flag_s && code_top)
                err_q <= 1'b1;

            if (accept)
                hold_q <= 1'b1;
            else if (state_q == ST_IDLE && !en_req_i)
                hold_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        busy_o    = (state_q == ST_CLEAR) || (state_q == ST_SETTLE) || (state_q == ST_PROBE);
        done_o    = (state_q == ST_FINISH);
        err_o     = err_q;
        chan_en_o = (state_q == ST_IDLE) && en_req_i && !hold_q;
    end

    // R2: channel is off for the whole search
    a_r2_chan_off_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !chan_en_o);

    // R5: the code only steps upward by one during a search
    a_r5_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && trim_o != $past(trim_o))
            |-> trim_o == $past(trim_o) + TRIM_W'(1));

    // R6: error only rises with the top code on the output
    a_r6_err_at_top: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> trim_o == TRIM_TOP);

    // R7: single-cycle done, never together with busy
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r7_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R8: channel remains off right after a search
    a_r8_hold_after: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !chan_en_o);

    // R9: start during a search does not reset the code
    a_r9_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && trim_o != '0) |=> trim_o != '0);

    // R10: an accepted start clears the error flag
    a_r10_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && !done_o) |=> !err_o);
endmodule

// File: tb/trim_cal_seq_test.sv
module trim_cal_seq_test;
    localparam int S   = 16;
    localparam int TW  = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic en_req_i = 1'b1;
    logic [TW-1:0] trim_o;
    logic chan_en_o, busy_o, done_o, err_o;
    logic cal_flag_i;

    int  target = 0;
    bit  man_mode = 1'b0;
    bit  man_flag = 1'b0;
    int  man_at = -1;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    assign cal_flag_i = man_mode ? man_flag : (int'(trim_o) >= target);

    trim_cal_seq #(.CLK_HZ(1_000_000), .SETTLE_US(S), .TRIM_W(TW), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cal_flag_i(cal_flag_i),
        .en_req_i(en_req_i), .trim_o(trim_o), .chan_en_o(chan_en_o),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o));

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    // stimulus table: target code (32 = flag never sets), expected trim, expected error
    localparam int NV = 6;
    localparam int V_TGT[NV]  = '{0, 1, 5, 17, 31, 32};
    localparam int V_TRIM[NV] = '{0, 1, 5, 17, 31, 31};
    localparam int V_ERR[NV]  = '{0, 0, 0, 0,  0,  1};

    // Runs one search; poke_at > 0 pulses start again at that edge count.
    task automatic run_cal(input int exp_trim, input int exp_err, input int poke_at,
                           input string tag);
        int n = 0;
        int prev;
        bit bad_step = 0;
        bit bad_en = 0;
        bit seen = 0;
        @(negedge clk); start_i = 1'b1;
        @(posedge clk);
        @(negedge clk); start_i = 1'b0;
        // R2: entry into search
        chk(busy_o && !chan_en_o && trim_o == 0, {"R2 entry ", tag},
            {busy_o, chan_en_o, trim_o}, 32'b1_0_00000 << 0 | (1 << (TW+1)));
        // R10: error cleared by accepted start
        chk(err_o == 1'b0, {"R10 clear ", tag}, err_o, 0);
        prev = int'(trim_o);
        while (n < 2000) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (man_mode && n == man_at) man_flag = 1'b1;
            if (poke_at > 0 && n == poke_at) start_i = 1'b1;
            if (poke_at > 0 && n == poke_at + 1) start_i = 1'b0;
            if (done_o) begin seen = 1; break; end
            if (busy_o && chan_en_o) bad_en = 1;
            if (busy_o && int'(trim_o) != prev && int'(trim_o) != prev + 1) bad_step = 1;
            prev = int'(trim_o);
        end
        start_i = 1'b0;
        chk(seen, {"R7 done seen ", tag}, seen, 1);
        chk(n == 1 + (exp_trim + 1) * (S + 1), {"R3 latency ", tag}, n, 1 + (exp_trim + 1) * (S + 1));
        chk(int'(trim_o) == exp_trim, {"R4/R6 trim ", tag}, trim_o, exp_trim);
        chk(int'(err_o) == exp_err, {"R6 err ", tag}, err_o, exp_err);
        chk(!busy_o, {"R7 busy low at done ", tag}, busy_o, 0);
        chk(!bad_en, {"R2 chan off during search ", tag}, bad_en, 0);
        chk(!bad_step, {"R5 step +1 ", tag}, bad_step, 0);
        @(negedge clk);
        chk(!done_o, {"R7 single pulse ", tag}, done_o, 0);
        chk(!chan_en_o, {"R8 hold off ", tag}, chan_en_o, 0);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(trim_o == 0, "R1 trim", trim_o, 0);
        chk(!busy_o, "R1 busy", busy_o, 0);
        chk(!done_o && !err_o, "R1 done/err", {done_o, err_o}, 0);
        chk(chan_en_o == en_req_i, "R1 chan_en", chan_en_o, en_req_i);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(trim_o == 0 && !busy_o && chan_en_o, "R1 after reset", {trim_o, busy_o, chan_en_o}, 1);

        for (int i = 0; i < NV; i++) begin
            target = V_TGT[i];
            run_cal(V_TRIM[i], V_ERR[i], 0, $sformatf("vec%0d", i));
        end

        // R10: error persists in idle until next start
        repeat (5) @(negedge clk);
        chk(err_o == 1'b1, "R10 err held", err_o, 1);

        // R8: re-enable only after request dropped
        repeat (3) @(negedge clk);
        chk(!chan_en_o, "R8 still off with req high", chan_en_o, 0);
        en_req_i = 1'b0;
        @(negedge clk);
        chk(!chan_en_o, "R8 off with req low", chan_en_o, 0);
        en_req_i = 1'b1;
        @(negedge clk);
        chk(chan_en_o, "R8 follows req again", chan_en_o, 1);

        // R9: start during search ignored (also clears err via R10 at its start)
        target = 4;
        run_cal(4, 0, 30, "R9 poke");

        // R11: late-rising flag missed at code 3, early one caught
        man_mode = 1'b1;
        man_flag = 1'b0;
        man_at = 1 + 3 * (S + 1) + S - 1;
        run_cal(4, 0, 0, "R11 late");
        man_flag = 1'b0;
        man_at = 1 + 3 * (S + 1) + S - 2;
        run_cal(3, 0, 0, "R11 early");
        man_mode = 1'b0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule